// File: doc/BRIEF.md
# Serial EEPROM Command Front End

This block is the slave-side serial engine that sits between the SPI pins of a small serial EEPROM and its array and status logic. It runs on the system clock, which must be at least eight times the serial clock. All four pins (chip select, serial clock, data in, hold) pass through a synchroniser. Serial clock edges are then found by comparing successive synchronised samples. Bits are taken MSB first on rising serial clock edges, and read data is shifted out on falling edges. Both idle polarities of the serial clock (polarity/phase 0,0 and 1,1) work without configuration.

Every whole byte received is reported as a one-cycle event carrying the byte, its position in the transfer (0 is the opcode) and, for write data, its target address. The array or status logic fetches outgoing bytes through a request/address/data triple. A commit pulse asks it to start a non-volatile cycle, and this happens only when chip select rises on a legal byte boundary. A hold input pauses the serial sequence without losing its position.

The sequencer states are: IDLE (deselected), OPCODE (receiving the instruction), ADDRESS (receiving the low address byte), WR_DATA (receiving write data), RD_DATA (sending array or status data), SR_DATA (receiving the status byte), SR_DONE (status byte complete, waiting for deselect), WAIT (instruction done, clocks ignored) and REJECT (unknown opcode). Transitions: a chip select fall goes from any state to OPCODE, and a chip select rise goes from any state to IDLE. The eighth opcode bit leads to WAIT, RD_DATA, SR_DATA, ADDRESS or REJECT, depending on the opcode. The eighth address bit leads to RD_DATA for a read and to WR_DATA for a write. The eighth status bit leads to SR_DATA→SR_DONE. Any further rising edge leads to SR_DONE→WAIT.

Top module: `spi_eeprom_front`

## Requirements
- R1: After reset, no byte is accepted until chip select has been seen high and then falls; clocking with chip select held low through reset produces no event and leaves `cmd_o` at 0.
- R2: Each group of eight rising serial clock edges in OPCODE, ADDRESS, WR_DATA or SR_DATA yields exactly one single-cycle `evt_valid_o` pulse. The pulse carries the byte assembled MSB first and its index, starting at 0 for the opcode.
- R3: Opcodes with upper nibble 0000 decode by their low three bits: x110 gives `cmd_o`=1 (set write enable), x100 gives 2 (clear write enable), x101 gives 3 (read status), x001 gives 4 (write status), A011 gives 5 (read) and A010 gives 6 (write). Bit 3 is ignored for codes 1 to 4.
- R4: Any other opcode leaves `cmd_o` at 0, produces no further events, and keeps `miso_oe_o` low until chip select rises.
- R5: After a set- or clear-write-enable opcode, further serial clocks produce no events until deselect.
- R6: For a read, the address is {opcode bit 3, address byte}. Data is driven MSB first, changing after falling serial clock edges. The address advances after each byte and wraps from 0x1FF to 0x000.
- R7: Read status sends the byte on `rd_data_i` and repeats it every eight clocks for as long as clocking continues.
- R8: Each write data byte reports its target address in `evt_addr_o`. The address then advances only within its 16-byte page, so 0x0FF is followed by 0x0F0.
- R9: `commit_array_o` pulses once when chip select rises in WR_DATA after at least one whole data byte and on a byte boundary. Otherwise no commit occurs.
- R10: `commit_status_o` pulses once when chip select rises after exactly eight status bits (clock 16). A 17th rising edge cancels it.
- R11: A hold fall while the serial clock is low freezes the sequence: serial clock edges are ignored and `miso_oe_o` is low. A hold rise while the clock is low resumes the sequence at the same bit.
- R12: `miso_oe_o` is low whenever chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cs_n_i | input | 1 | Chip select pin, active low |
| sck_i | input | 1 | Serial clock pin |
| mosi_i | input | 1 | Serial data in pin |
| hold_n_i | input | 1 | Hold pin, active low |
| miso_o | output | 1 | Serial data out value |
| miso_oe_o | output | 1 | Output enable for serial data out (low = high impedance) |
| cmd_o | output | 3 | Decoded instruction of the current selection |
| evt_valid_o | output | 1 | One-cycle pulse: a byte was received |
| evt_byte_o | output | 8 | Received byte |
| evt_idx_o | output | IDX_W | Byte index in the transfer, saturating |
| evt_addr_o | output | 9 | Target address for write data bytes, 0 otherwise |
| rd_req_o | output | 1 | One-cycle request for the next outgoing byte |
| rd_addr_o | output | 9 | Current address counter |
| rd_data_i | input | 8 | Outgoing byte, valid one cycle after the request |
| commit_array_o | output | 1 | Start a non-volatile array write |
| commit_status_o | output | 1 | Start a non-volatile status write |

## Verification
Two functions can coincide in one system clock cycle. A chip select rise can land in the same cycle as a byte-completing serial edge, and a hold request can land on the same synchronised sample as a serial clock edge. The bench provokes the first by deselecting straight after the eighth data or status bit. It then judges the outcome by whether a commit appears alongside, or in place of, the last byte event. For the second, it drops hold just after a falling edge that has loaded the next read byte. It then checks that the output enable falls, that toggles while held change nothing, and that the byte read after release still matches the expected address.

// File: rtl/eep_front_pkg.sv
package eep_front_pkg;

    typedef enum logic [2:0] {
        CMD_NONE  = 3'd0,
        CMD_WREN  = 3'd1,
        CMD_WRDI  = 3'd2,
        CMD_RDSR  = 3'd3,
        CMD_WRSR  = 3'd4,
        CMD_READ  = 3'd5,
        CMD_WRITE = 3'd6
    } cmd_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_ADDRESS,
        ST_WR_DATA,
        ST_RD_DATA,
        ST_SR_DATA,
        ST_SR_DONE,
        ST_WAIT,
        ST_REJECT
    } state_e;

    function automatic cmd_e decode_op(input logic [7:0] op);
        cmd_e c;
        c = CMD_NONE;
        if (op[7:4] == 4'b0000) begin
            unique case (op[2:0])
                3'b110:  c = CMD_WREN;
                3'b100:  c = CMD_WRDI;
                3'b101:  c = CMD_RDSR;
                3'b001:  c = CMD_WRSR;
                3'b011:  c = CMD_READ;
                3'b010:  c = CMD_WRITE;
                default: c = CMD_NONE;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/eep_pin_sync.sv
module eep_pin_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] pin_s
);
    for (genvar g = 0; g < W; g++) begin : g_pin
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], pin_i[g]};
        end
        assign pin_s[g] = chain[STAGES-1];
    end
endmodule

// File: rtl/eep_hold_ctl.sv
module eep_hold_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_s,
    input  logic hold_q,
    input  logic sck_s,
    input  logic cs_sel,
    output logic held
);
    logic hold_fall, hold_rise;
    assign hold_fall = hold_q & ~hold_s;
    assign hold_rise = ~hold_q & hold_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                held <= 1'b0;
        else if (hold_fall && !sck_s && cs_sel)    held <= 1'b1;
        else if (hold_rise && !sck_s)              held <= 1'b0;
    end
endmodule

// File: rtl/eep_tx_shift.sv
module eep_tx_shift (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       shift,
    input  logic [7:0] data_i,
    output logic       bit_o,
    output logic       live
);
    logic [7:0] sh;
    logic [2:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh   <= '0;
            cnt  <= '0;
            live <= 1'b0;
        end else if (clear) begin
            cnt  <= '0;
            live <= 1'b0;
        end else if (shift) begin
            sh   <= (cnt == 3'd0) ? data_i : {sh[6:0], 1'b0};
            cnt  <= cnt + 3'd1;
            live <= 1'b1;
        end
    end

    assign bit_o = sh[7];
endmodule

// File: rtl/spi_eeprom_front.sv
module spi_eeprom_front
    import eep_front_pkg::*;
#(
    parameter int IDX_W       = 5,
    parameter int PAGE_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n_i,
    input  logic             sck_i,
    input  logic             mosi_i,
    input  logic             hold_n_i,
    output logic             miso_o,
    output logic             miso_oe_o,
    output logic [2:0]       cmd_o,
    output logic             evt_valid_o,
    output logic [7:0]       evt_byte_o,
    output logic [IDX_W-1:0] evt_idx_o,
    output logic [8:0]       evt_addr_o,
    output logic             rd_req_o,
    output logic [8:0]       rd_addr_o,
    input  logic [7:0]       rd_data_i,
    output logic             commit_array_o,
    output logic             commit_status_o
);
    localparam int         ADDR_W    = 9;
    localparam logic [8:0] PAGE_MASK = 9'((1 << PAGE_W) - 1);

    // pin synchronisation and edge detection
    logic [3:0] pins_s;
    logic       cs_s, sck_s, mosi_s, hold_s;
    logic       cs_q, sck_q, hold_q;
    logic       cs_sel, cs_fall, cs_rise, sck_rise, sck_fall, held;

    eep_pin_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i ({hold_n_i, mosi_i, sck_i, cs_n_i}),
        .pin_s (pins_s)
    );
    assign {hold_s, mosi_s, sck_s, cs_s} = pins_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) {cs_q, sck_q, hold_q} <= '0;
        else        {cs_q, sck_q, hold_q} <= {cs_s, sck_s, hold_s};
    end

    assign cs_sel   = ~cs_s;
    assign cs_fall  = cs_q & ~cs_s;
    assign cs_rise  = ~cs_q & cs_s;
    assign sck_rise = sck_s & ~sck_q & ~held;
    assign sck_fall = ~sck_s & sck_q & ~held;

    eep_hold_ctl u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold_s (hold_s),
        .hold_q (hold_q),
        .sck_s  (sck_s),
        .cs_sel (cs_sel),
        .held   (held)
    );

    // sequencer
    state_e            state, nxt;
    cmd_e              cur_cmd, op_cmd;
    logic [2:0]        bit_cnt;
    logic [6:0]        sreg;
    logic [7:0]        in_byte;
    logic              last_bit, accepting, a8, got_data;
    logic [IDX_W-1:0]  byte_idx;
    logic [ADDR_W-1:0] addr;

    assign in_byte   = {sreg, mosi_s};
    assign last_bit  = (bit_cnt == 3'd7);
    assign op_cmd    = decode_op(in_byte);
    assign accepting = (state == ST_OPCODE)  || (state == ST_ADDRESS) ||
                       (state == ST_WR_DATA) || (state == ST_RD_DATA) ||
                       (state == ST_SR_DATA);

    always_comb begin
        nxt = state;
        if (cs_rise) begin
            nxt = ST_IDLE;
        end else if (cs_fall) begin
            nxt = ST_OPCODE;
        end else if (sck_rise) begin
            unique case (state)
                ST_OPCODE: if (last_bit) begin
                    unique case (op_cmd)
                        CMD_WREN, CMD_WRDI:  nxt = ST_WAIT;
                        CMD_RDSR:            nxt = ST_RD_DATA;
                        CMD_WRSR:            nxt = ST_SR_DATA;
                        CMD_READ, CMD_WRITE: nxt = ST_ADDRESS;
                        default:             nxt = ST_REJECT;
                    endcase
                end
                ST_ADDRESS: if (last_bit)
                    nxt = (cur_cmd == CMD_READ) ? ST_RD_DATA : ST_WR_DATA;
                ST_SR_DATA: if (last_bit) nxt = ST_SR_DONE;
                ST_SR_DONE: nxt = ST_WAIT;
                default:    nxt = state;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_cmd         <= CMD_NONE;
            bit_cnt         <= '0;
            sreg            <= '0;
            a8              <= 1'b0;
            got_data        <= 1'b0;
            byte_idx        <= '0;
            addr            <= '0;
            evt_valid_o     <= 1'b0;
            evt_byte_o      <= '0;
            evt_idx_o       <= '0;
            evt_addr_o      <= '0;
            rd_req_o        <= 1'b0;
            commit_array_o  <= 1'b0;
            commit_status_o <= 1'b0;
        end else begin
            evt_valid_o     <= 1'b0;
            rd_req_o        <= 1'b0;
            commit_array_o  <= 1'b0;
            commit_status_o <= 1'b0;
            if (cs_rise) begin
                commit_array_o  <= (state == ST_WR_DATA) && (bit_cnt == 3'd0) && got_data;
                commit_status_o <= (state == ST_SR_DONE);
                cur_cmd         <= CMD_NONE;
            end else if (cs_fall) begin
                bit_cnt  <= '0;
                byte_idx <= '0;
                got_data <= 1'b0;
                cur_cmd  <= CMD_NONE;
            end else if (sck_rise && accepting) begin
                sreg    <= in_byte[6:0];
                bit_cnt <= bit_cnt + 3'd1;
                if (last_bit) begin
                    if (state != ST_RD_DATA) begin
                        evt_valid_o <= 1'b1;
                        evt_byte_o  <= in_byte;
                        evt_idx_o   <= byte_idx;
                        evt_addr_o  <= (state == ST_WR_DATA) ? addr : '0;
                        if (byte_idx != '1) byte_idx <= byte_idx + 1'b1;
                    end
                    unique case (state)
                        ST_OPCODE: begin
                            cur_cmd  <= op_cmd;
                            a8       <= in_byte[3];
                            rd_req_o <= (op_cmd == CMD_RDSR);
                        end
                        ST_ADDRESS: begin
                            addr     <= {a8, in_byte};
                            rd_req_o <= (cur_cmd == CMD_READ);
                        end
                        ST_WR_DATA: begin
                            addr     <= (addr & ~PAGE_MASK) | ((addr + 9'd1) & PAGE_MASK);
                            got_data <= 1'b1;
                        end
                        ST_RD_DATA: begin
                            if (cur_cmd == CMD_READ) addr <= addr + 9'd1;
                            rd_req_o <= 1'b1;
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    // output shifter
    logic tx_bit, tx_live;

    eep_tx_shift u_tx (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  ((state != ST_RD_DATA) && (nxt == ST_RD_DATA)),
        .shift  (sck_fall && (state == ST_RD_DATA)),
        .data_i (rd_data_i),
        .bit_o  (tx_bit),
        .live   (tx_live)
    );

    assign miso_o    = tx_bit;
    assign miso_oe_o = (state == ST_RD_DATA) && tx_live && !held && cs_sel;
    assign cmd_o     = cur_cmd;
    assign rd_addr_o = addr;

endmodule

// File: rtl/eep_front_chk.sv
module eep_front_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_sel,
    input logic held,
    input logic miso_oe,
    input logic evt_valid,
    input logic rd_req,
    input logic commit_array,
    input logic commit_status
);
    a_r12_oe_only_selected: assert property (@(posedge clk) disable iff (!rst_n)
        miso_oe |-> cs_sel);

    a_r11_held_output_off: assert property (@(posedge clk) disable iff (!rst_n)
        held |-> !miso_oe);

    a_r9_commit_at_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        commit_array |-> (!cs_sel && $past(cs_sel, 2)));

    a_r10_commit_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit_array && commit_status));

    a_r2_event_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |=> !evt_valid);

    a_r6_request_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req);
endmodule

bind spi_eeprom_front eep_front_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cs_sel        (cs_sel),
    .held          (held),
    .miso_oe       (miso_oe_o),
    .evt_valid     (evt_valid_o),
    .rd_req        (rd_req_o),
    .commit_array  (commit_array_o),
    .commit_status (commit_status_o)
);

// File: tb/spi_eeprom_front_bench.sv
module spi_eeprom_front_bench;
    localparam int HP = 8;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst_n, cs_n, sck, mosi, hold_n;
    logic       miso, miso_oe, evt_valid, rd_req, c_arr, c_st;
    logic [2:0] cmd;
    logic [7:0] evt_byte, rd_data;
    logic [4:0] evt_idx;
    logic [8:0] evt_addr, rd_addr;

    spi_eeprom_front u_spi_eeprom_front (
        .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sck_i(sck), .mosi_i(mosi),
        .hold_n_i(hold_n), .miso_o(miso), .miso_oe_o(miso_oe), .cmd_o(cmd),
        .evt_valid_o(evt_valid), .evt_byte_o(evt_byte), .evt_idx_o(evt_idx),
        .evt_addr_o(evt_addr), .rd_req_o(rd_req), .rd_addr_o(rd_addr),
        .rd_data_i(rd_data), .commit_array_o(c_arr), .commit_status_o(c_st)
    );

    function automatic logic [7:0] mem_byte(input logic [8:0] a);
        return a[7:0] ^ 8'h5A ^ {7'b0, a[8]};
    endfunction
    assign rd_data = (cmd == 3'd3) ? 8'h3C : mem_byte(rd_addr);

    typedef struct { int kind; int b; int idx; int a; bit ca; string req; } item_t;
    item_t q[$];
    int  checks = 0, errors = 0;
    bit  mode3 = 1'b0, finished = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic push_evt(input int b, input int idx, input int a, input bit ca, input string req);
        item_t it;
        it.kind = 0; it.b = b; it.idx = idx; it.a = a; it.ca = ca; it.req = req;
        q.push_back(it);
    endtask

    task automatic push_commit(input int kind, input string req);
        item_t it;
        it.kind = kind; it.b = 0; it.idx = 0; it.a = 0; it.ca = 0; it.req = req;
        q.push_back(it);
    endtask

    // monitor: pops expectations as results appear
    always @(negedge clk) begin
        item_t it;
        if (rst_n && evt_valid) begin
            if (q.size() == 0) chk(0, "R2", "unexpected byte event", evt_byte, 0);
            else begin
                it = q.pop_front();
                chk(it.kind == 0, it.req, "event kind", 0, it.kind);
                chk(evt_byte == 8'(it.b), it.req, "event byte", evt_byte, it.b);
                chk(evt_idx == 5'(it.idx), it.req, "event index", evt_idx, it.idx);
                if (it.ca) chk(evt_addr == 9'(it.a), it.req, "event address", evt_addr, it.a);
            end
        end
        if (rst_n && (c_arr || c_st)) begin
            if (q.size() == 0) chk(0, c_arr ? "R9" : "R10", "unexpected commit", c_arr, 0);
            else begin
                it = q.pop_front();
                chk(it.kind == (c_arr ? 1 : 2), it.req, "commit kind", c_arr ? 1 : 2, it.kind);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sel();
        sck = mode3; tick(HP); cs_n = 1'b0; tick(HP);
    endtask

    task automatic desel();
        if (!mode3) sck = 1'b0;
        tick(HP); cs_n = 1'b1; tick(2 * HP);
    endtask

    task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            mosi = tx[i]; sck = 1'b0; tick(HP);
            sck = 1'b1; rx[i] = miso; tick(HP);
        end
    endtask

    task automatic xbits(input int n);
        for (int i = 0; i < n; i++) begin
            mosi = 1'b1; sck = 1'b0; tick(HP); sck = 1'b1; tick(HP);
        end
    endtask

    task automatic drained(input string req);
        tick(4);
        chk(q.size() == 0, req, "pending expected items", q.size(), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] rx;
        rst_n = 1'b0; cs_n = 1'b0; sck = 1'b0; mosi = 1'b0; hold_n = 1'b1;
        tick(5);
        chk(miso_oe == 0 && evt_valid == 0 && c_arr == 0 && c_st == 0, "R12", "reset outputs", miso_oe, 0);
        chk(cmd == 0, "R1", "reset command", cmd, 0);
        rst_n = 1'b1; tick(HP);

        // R1: selected through reset, no select edge seen
        xbyte(8'h06, rx);
        drained("R1");
        chk(cmd == 0, "R1", "command without select edge", cmd, 0);
        cs_n = 1'b1; tick(2 * HP);

        // R3/R5: write enable, then clocks ignored
        sel(); push_evt(8'h06, 0, 0, 0, "R3");
        xbyte(8'h06, rx); tick(4);
        chk(cmd == 1, "R3", "set write enable code", cmd, 1);
        xbyte(8'hFF, rx); xbyte(8'h02, rx);
        drained("R5");
        desel(); drained("R5");

        // R3: bit 3 ignored; clear write enable
        sel(); push_evt(8'h0E, 0, 0, 0, "R3"); xbyte(8'h0E, rx); tick(4);
        chk(cmd == 1, "R3", "bit3 ignored", cmd, 1); desel();
        sel(); push_evt(8'h04, 0, 0, 0, "R3"); xbyte(8'h04, rx); tick(4);
        chk(cmd == 2, "R3", "clear write enable code", cmd, 2); desel(); drained("R3");

        // R8/R9: single byte write, mode 1,1, A8 from opcode
        mode3 = 1'b1;
        sel();
        push_evt(8'h0A, 0, 0, 0, "R2"); push_evt(8'hF3, 1, 0, 0, "R2");
        push_evt(8'h99, 2, 9'h1F3, 1, "R8"); push_commit(1, "R9");
        xbyte(8'h0A, rx); tick(4);
        chk(cmd == 6, "R3", "write code", cmd, 6);
        xbyte(8'hF3, rx); xbyte(8'h99, rx);
        desel(); drained("R9");

        // R8: page wrap
        sel();
        push_evt(8'h02, 0, 0, 0, "R8"); push_evt(8'hFE, 1, 0, 0, "R8");
        push_evt(8'h11, 2, 9'h0FE, 1, "R8"); push_evt(8'h22, 3, 9'h0FF, 1, "R8");
        push_evt(8'h33, 4, 9'h0F0, 1, "R8"); push_commit(1, "R9");
        xbyte(8'h02, rx); xbyte(8'hFE, rx); xbyte(8'h11, rx); xbyte(8'h22, rx); xbyte(8'h33, rx);
        desel(); drained("R8");

        // R9: deselect off boundary, and with no data byte
        mode3 = 1'b0;
        sel();
        push_evt(8'h02, 0, 0, 0, "R9"); push_evt(8'h10, 1, 0, 0, "R9");
        push_evt(8'h55, 2, 9'h010, 1, "R9");
        xbyte(8'h02, rx); xbyte(8'h10, rx); xbyte(8'h55, rx); xbits(4);
        desel(); drained("R9");
        sel(); push_evt(8'h02, 0, 0, 0, "R9"); push_evt(8'h10, 1, 0, 0, "R9");
        xbyte(8'h02, rx); xbyte(8'h10, rx); desel(); drained("R9");

        // R6: read across the top of the address space
        sel();
        push_evt(8'h0B, 0, 0, 0, "R6"); push_evt(8'hFE, 1, 0, 0, "R6");
        xbyte(8'h0B, rx); xbyte(8'hFE, rx);
        xbyte(8'h00, rx); chk(rx == mem_byte(9'h1FE), "R6", "read 0x1FE", rx, mem_byte(9'h1FE));
        chk(miso_oe == 1, "R6", "output enabled during read", miso_oe, 1);
        xbyte(8'h00, rx); chk(rx == mem_byte(9'h1FF), "R6", "read 0x1FF", rx, mem_byte(9'h1FF));
        xbyte(8'h00, rx); chk(rx == mem_byte(9'h000), "R6", "read wrap 0x000", rx, mem_byte(9'h000));
        desel(); drained("R6");
        chk(miso_oe == 0, "R12", "output off after deselect", miso_oe, 0);

        // R7: status read repeats, mode 1,1
        mode3 = 1'b1;
        sel(); push_evt(8'h05, 0, 0, 0, "R7");
        xbyte(8'h05, rx);
        xbyte(8'h00, rx); chk(rx == 8'h3C, "R7", "status byte", rx, 8'h3C);
        xbyte(8'h00, rx); chk(rx == 8'h3C, "R7", "status repeat", rx, 8'h3C);
        desel(); drained("R7");

        // R10: status write on clock 16, then with a 17th clock
        sel(); push_evt(8'h01, 0, 0, 0, "R10"); push_evt(8'h0C, 1, 0, 0, "R10"); push_commit(2, "R10");
        xbyte(8'h01, rx); xbyte(8'h0C, rx); desel(); drained("R10");
        sel(); push_evt(8'h01, 0, 0, 0, "R10"); push_evt(8'h0C, 1, 0, 0, "R10");
        xbyte(8'h01, rx); xbyte(8'h0C, rx); xbits(1); desel(); drained("R10");

        // R4: invalid opcodes
        mode3 = 1'b0;
        sel(); push_evt(8'h13, 0, 0, 0, "R4");
        xbyte(8'h13, rx); xbyte(8'h00, rx); xbyte(8'h00, rx);
        chk(cmd == 0, "R4", "invalid command code", cmd, 0);
        chk(miso_oe == 0, "R4", "output off after invalid", miso_oe, 0);
        desel(); drained("R4");
        sel(); push_evt(8'h07, 0, 0, 0, "R4");
        xbyte(8'h07, rx); xbyte(8'h00, rx); desel(); drained("R4");

        // R11: hold inside a write
        sel();
        push_evt(8'h02, 0, 0, 0, "R11"); push_evt(8'h20, 1, 0, 0, "R11");
        push_evt(8'hA1, 2, 9'h020, 1, "R11"); push_evt(8'hB2, 3, 9'h021, 1, "R11");
        push_commit(1, "R11");
        xbyte(8'h02, rx); xbyte(8'h20, rx); xbyte(8'hA1, rx);
        sck = 1'b0; tick(HP); hold_n = 1'b0; tick(HP);
        xbits(4); sck = 1'b0; tick(HP);
        hold_n = 1'b1; tick(HP);
        xbyte(8'hB2, rx); desel(); drained("R11");

        // R11: hold inside a read
        sel(); push_evt(8'h03, 0, 0, 0, "R11"); push_evt(8'h40, 1, 0, 0, "R11");
        xbyte(8'h03, rx); xbyte(8'h40, rx);
        xbyte(8'h00, rx); chk(rx == mem_byte(9'h040), "R11", "read before hold", rx, mem_byte(9'h040));
        sck = 1'b0; tick(HP); hold_n = 1'b0; tick(HP);
        chk(miso_oe == 0, "R11", "output off while held", miso_oe, 0);
        xbits(5); sck = 1'b0; tick(HP);
        hold_n = 1'b1; tick(HP);
        chk(miso_oe == 1, "R11", "output back after release", miso_oe, 1);
        xbyte(8'h00, rx); chk(rx == mem_byte(9'h041), "R11", "read after hold", rx, mem_byte(9'h041));
        desel(); drained("R11");

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule